// File: doc/BRIEF.md
# Wiper Position Register with One-Hot Tap Select

This block keeps the volatile position of a digitally set potentiometer wiper. It also turns that position into a registered one-hot select that drives the tap switches of a resistor ladder. The position changes in four ways:

- The host writes a new code directly.
- A stored setting is copied in from one of several data registers, which are presented as a flat bus.
- The position moves one step per clock up or down.
- A recall strobe, raised once after power is applied, copies in stored setting 0.

Nothing is written back from this register to storage.

All update inputs are single-cycle strobes sampled on the rising clock edge. The block accepts every strobe in the cycle it arrives, so it has no handshake and no back-pressure. When several strobes arrive together, the highest-priority one is taken and the rest are dropped. A step that would move past either end of the code range is dropped, so the wiper rests on the end terminal.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pos` is 0 and `tap_sel` has only bit 0 set.
- R2: `tap_sel` always has exactly one bit set, and that bit's index equals `pos`. Both change in the same clock cycle.
- R3: Code 0 selects `tap_sel[0]`, the low-terminal tap. The all-ones code (3Fh for 6 bits) selects the top bit, `tap_sel[63]`, the high-terminal tap.
- R4: With `step_en` high and no load strobe, `pos` goes up by one after the edge if `step_up` is 1, and down by one if `step_up` is 0.
- R5: A step up at the all-ones code, or a step down at 0, leaves `pos` unchanged.
- R6: `wr_stb` loads `wr_data` into `pos` at the next edge.
- R7: `xfer_stb` loads the stored word picked by `xfer_sel` into `pos`. Word i sits at `dr_bank[6*i+5 : 6*i]`.
- R8: `recall_stb` loads word 0 of `dr_bank` (bits 5:0) into `pos`.
- R9: The strobes rank as follows, highest first: `recall_stb`, `wr_stb`, `xfer_stb`, `step_en`. Lower-ranked strobes in the same cycle have no effect.
- R10: In a cycle with no strobe, `pos` and `tap_sel` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_stb | input | 1 | Power-up recall of stored word 0 |
| wr_stb | input | 1 | Direct host write strobe |
| wr_data | input | 6 | Position code for a host write |
| xfer_stb | input | 1 | Parallel load from a stored word |
| xfer_sel | input | 2 | Index of the stored word to load |
| dr_bank | input | 24 | Stored words, word i at bits 6i+5:6i |
| step_en | input | 1 | Move one step this cycle |
| step_up | input | 1 | Step direction: 1 toward high end, 0 toward low end |
| pos | output | 6 | Current wiper position |
| tap_sel | output | 64 | One-hot tap switch select |

## Verification
A wrong position register shows at both outputs in the very next cycle. The `pos` code and the index of the set `tap_sel` bit move together, so an error in the step, load or priority logic is seen one edge after the strobe that caused it. A decoder fault can show in three ways in that same cycle: no bit set, two bits set, or a set bit that does not match `pos`. The saturation corners and the priority corners are each driven directly, because an error there stays invisible in normal stepping.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // Which source updates the position this cycle, highest rank first.
  typedef enum logic [2:0] {
    UPD_RECALL,
    UPD_WRITE,
    UPD_XFER,
    UPD_STEP,
    UPD_HOLD
  } upd_e;
endpackage

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
  import wiper_pkg::*;
#(
  parameter int POS_W  = 6,
  parameter int NUM_DR = 4,
  parameter int SEL_W  = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    recall_stb,
  input  logic                    wr_stb,
  input  logic [POS_W-1:0]        wr_data,
  input  logic                    xfer_stb,
  input  logic [SEL_W-1:0]        xfer_sel,
  input  logic [NUM_DR*POS_W-1:0] dr_bank,
  input  logic                    step_en,
  input  logic                    step_up,
  output logic [POS_W-1:0]        pos_d,
  output logic [POS_W-1:0]        pos_q
);
  localparam logic [POS_W-1:0] CODE_MAX = '1;
  localparam logic [POS_W-1:0] CODE_MIN = '0;

  logic [POS_W-1:0] dr_word [NUM_DR];
  logic [POS_W-1:0] xfer_word;
  logic             at_top, at_bot;
  upd_e             upd;

  for (genvar g = 0; g < NUM_DR; g++) begin : g_word
    assign dr_word[g] = dr_bank[g*POS_W +: POS_W];
  end

  assign xfer_word = (int'(xfer_sel) < NUM_DR) ? dr_word[xfer_sel] : pos_q;
  assign at_top    = (pos_q == CODE_MAX);
  assign at_bot    = (pos_q == CODE_MIN);

  always_comb begin
    if (recall_stb)    upd = UPD_RECALL;
    else if (wr_stb)   upd = UPD_WRITE;
    else if (xfer_stb) upd = UPD_XFER;
    else if (step_en)  upd = UPD_STEP;
    else               upd = UPD_HOLD;
  end

  always_comb begin
    unique case (upd)
      UPD_RECALL: pos_d = dr_word[0];
      UPD_WRITE:  pos_d = wr_data;
      UPD_XFER:   pos_d = xfer_word;
      UPD_STEP: begin
        if (step_up) pos_d = at_top ? pos_q : pos_q + POS_W'(1);
        else         pos_d = at_bot ? pos_q : pos_q - POS_W'(1);
      end
      default:    pos_d = pos_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= CODE_MIN;
    else        pos_q <= pos_d;
  end

  // Assertions guarding the update logic
  logic step_only, idle;
  assign step_only = step_en & ~recall_stb & ~wr_stb & ~xfer_stb;
  assign idle      = ~step_en & ~recall_stb & ~wr_stb & ~xfer_stb;

  a_r8_recall_word0: assert property (@(posedge clk) disable iff (!rst_n)
    recall_stb |=> pos_q == $past(dr_bank[POS_W-1:0]));
  a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !recall_stb) |=> pos_q == $past(wr_data));
  a_r7_xfer_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && !wr_stb && !recall_stb && int'(xfer_sel) < NUM_DR)
      |=> pos_q == $past(dr_bank[xfer_sel*POS_W +: POS_W]));
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_only && step_up && pos_q != CODE_MAX) |=> pos_q == $past(pos_q) + POS_W'(1));
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_only && !step_up && pos_q != CODE_MIN) |=> pos_q == $past(pos_q) - POS_W'(1));
  a_r5_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (step_only && step_up && pos_q == CODE_MAX) |=> $stable(pos_q));
  a_r5_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (step_only && !step_up && pos_q == CODE_MIN) |=> $stable(pos_q));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(pos_q));
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
  parameter int POS_W = 6,
  parameter int TAPS  = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] code_d,
  output logic [TAPS-1:0]  tap_q
);
  logic [TAPS-1:0] hot_d;

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign hot_d[g] = (code_d == POS_W'(g));
  end

  // Registered so the switch select never shows a decode glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= TAPS'(1);
    else        tap_q <= hot_d;
  end

  a_r2_single_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_q) == 1);
  a_r3_low_end: assert property (@(posedge clk) disable iff (!rst_n)
    (code_d == '0) |=> tap_q[0]);
  a_r3_high_end: assert property (@(posedge clk) disable iff (!rst_n)
    (code_d == '1) |=> tap_q[TAPS-1]);
endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl #(
  parameter int POS_W  = 6,
  parameter int NUM_DR = 4,
  localparam int SEL_W = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
  localparam int TAPS  = 1 << POS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    recall_stb,
  input  logic                    wr_stb,
  input  logic [POS_W-1:0]        wr_data,
  input  logic                    xfer_stb,
  input  logic [SEL_W-1:0]        xfer_sel,
  input  logic [NUM_DR*POS_W-1:0] dr_bank,
  input  logic                    step_en,
  input  logic                    step_up,
  output logic [POS_W-1:0]        pos,
  output logic [TAPS-1:0]         tap_sel
);
  logic [POS_W-1:0] pos_next;

  wiper_pos_reg #(.POS_W(POS_W), .NUM_DR(NUM_DR), .SEL_W(SEL_W)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .recall_stb (recall_stb),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .xfer_stb   (xfer_stb),
    .xfer_sel   (xfer_sel),
    .dr_bank    (dr_bank),
    .step_en    (step_en),
    .step_up    (step_up),
    .pos_d      (pos_next),
    .pos_q      (pos)
  );

  tap_decoder #(.POS_W(POS_W), .TAPS(TAPS)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_d (pos_next),
    .tap_q  (tap_sel)
  );

  // The register and the decoder are separate flops; they must agree.
  a_r2_tap_tracks_pos: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel[pos] == 1'b1);
endmodule

// File: tb/wiper_tap_ctrl_tb.sv
module wiper_tap_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        recall_stb = 1'b0, wr_stb = 1'b0, xfer_stb = 1'b0;
  logic        step_en = 1'b0, step_up = 1'b0;
  logic [5:0]  wr_data = '0;
  logic [1:0]  xfer_sel = '0;
  logic [23:0] dr_bank = {6'h07, 6'h3F, 6'h2A, 6'h15};
  logic [5:0]  pos;
  logic [63:0] tap_sel;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_tap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .recall_stb(recall_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .xfer_stb(xfer_stb), .xfer_sel(xfer_sel),
    .dr_bank(dr_bank), .step_en(step_en), .step_up(step_up),
    .pos(pos), .tap_sel(tap_sel)
  );

  // R2 is checked with every position check: one bit, at index pos.
  task automatic chk(input logic [5:0] exp, input string req);
    logic [63:0] exp_tap;
    exp_tap = 64'd1 << exp;
    checks++;
    if (pos !== exp || tap_sel !== exp_tap) begin
      errors++;
      $display("FAIL %s/R2: pos=%0h tap=%h expected pos=%0h tap=%h",
               req, pos, tap_sel, exp, exp_tap);
    end
  endtask

  // Apply strobes for one edge; return at the next falling edge.
  task automatic pulse(input logic rc, input logic wr, input logic [5:0] wd,
                       input logic xf, input logic [1:0] xs,
                       input logic se, input logic su);
    recall_stb = rc; wr_stb = wr; wr_data = wd;
    xfer_stb = xf; xfer_sel = xs; step_en = se; step_up = su;
    @(negedge clk);
    recall_stb = 0; wr_stb = 0; xfer_stb = 0; step_en = 0; step_up = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); chk(6'h00, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk); chk(6'h00, "R1 after reset");
  endtask

  task automatic t_recall();
    pulse(1, 0, 0, 0, 0, 0, 0); chk(6'h15, "R8 recall word0");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk(6'h15, "R10 idle hold");
    end
  endtask

  task automatic t_write_ends();
    pulse(0, 1, 6'h3F, 0, 0, 0, 0); chk(6'h3F, "R3/R6 write top code");
    pulse(0, 1, 6'h00, 0, 0, 0, 0); chk(6'h00, "R3/R6 write zero code");
    pulse(0, 1, 6'h2C, 0, 0, 0, 0); chk(6'h2C, "R6 write mid code");
  endtask

  task automatic t_xfer();
    logic [5:0] w;
    for (int i = 0; i < 4; i++) begin
      w = dr_bank[i*6 +: 6];
      pulse(0, 0, 0, 1, 2'(i), 0, 0);
      chk(w, $sformatf("R7 xfer word%0d", i));
    end
  endtask

  task automatic t_step();
    logic [5:0] e;
    e = 6'h07;                      // word 3 from the previous transfer
    for (int i = 0; i < 3; i++) begin
      pulse(0, 0, 0, 0, 0, 1, 1); e = e + 1; chk(e, "R4 step up");
    end
    for (int i = 0; i < 5; i++) begin
      pulse(0, 0, 0, 0, 0, 1, 0); e = e - 1; chk(e, "R4 step down");
    end
  endtask

  task automatic t_saturate();
    pulse(0, 1, 6'h3E, 0, 0, 0, 0);
    pulse(0, 0, 0, 0, 0, 1, 1); chk(6'h3F, "R4 step to top");
    pulse(0, 0, 0, 0, 0, 1, 1); chk(6'h3F, "R5 saturate top");
    pulse(0, 0, 0, 0, 0, 1, 1); chk(6'h3F, "R5 saturate top again");
    pulse(0, 1, 6'h01, 0, 0, 0, 0);
    pulse(0, 0, 0, 0, 0, 1, 0); chk(6'h00, "R4 step to bottom");
    pulse(0, 0, 0, 0, 0, 1, 0); chk(6'h00, "R5 saturate bottom");
  endtask

  task automatic t_priority();
    pulse(1, 1, 6'h01, 1, 2'd1, 1, 1); chk(6'h15, "R9 recall beats all");
    pulse(0, 1, 6'h01, 1, 2'd1, 1, 1); chk(6'h01, "R9 write beats xfer/step");
    pulse(0, 0, 0, 1, 2'd2, 1, 0);     chk(6'h3F, "R9 xfer beats step");
    pulse(0, 0, 0, 0, 0, 1, 0);        chk(6'h3E, "R9 step alone");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_recall();
    t_hold();
    t_write_ends();
    t_xfer();
    t_step();
    t_saturate();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule